// File: doc/BRIEF.md
# Burst pseudo-SRAM with WAIT

This block is a synthesizable model of a 16-bit synchronous burst pseudo-static RAM. A bus master opens a burst by pulling chip enable low. The block captures the start address and the direction on that clock edge and then paces the master with a registered, active-high `wait_o`. It raises `wait_o` for a fixed initial latency. The stall grows when the access collides with a self-timed internal refresh. During a long burst the block raises `wait_o` again each time the address steps into a new row. Data moves one word per clock once the stall is over. Two active-low byte enables mask the lanes of each beat.

The data path follows the rules of a valid/ready stream. `wait_o` is the inverse of ready, and the master holds chip enable low to mean valid. While a burst is open, a beat moves on every rising edge at which `ce_n` is low and `wait_o` is low. On a read, the master takes `dq_out` on the enabled lanes. On a write, the block stores `dq_in` on the enabled lanes. While `wait_o` is high, the master must hold its beat. A rising `ce_n` ends the burst. If `ce_n` rises before the first beat, the access is aborted and reported as corrupt. The storage is a small internal register array.

Top module: `bpsram_wait`

## Requirements
- R1: Reset values: while `rst_n` is low, and after it, until an access begins, `wait_o`, `dq_oe` and `corrupt` are all 0.
- R2: When idle with no refresh due or running, the edge that first sees `ce_n` low starts an access. `wait_o` is then 1 for exactly LAT_CYC cycles (default 3) and falls on the following edge. While `wait_o` is 1, `dq_oe` stays 0.
- R3: After `wait_o` falls, each edge with `ce_n` low transfers one beat at the current address. The address starts at the captured value and then increments by one per beat. On a read, `dq_out` carries the addressed word on the enabled lanes.
- R4: On a write beat, `lb_n` low stores `dq_in[7:0]` and `ub_n` low stores `dq_in[15:8]`. A lane whose enable is high keeps its previous content.
- R5: `dq_oe[0]` (bits 7:0) is 1 only during a read beat with `lb_n` low. `dq_oe[1]` (bits 15:8) is 1 only during a read beat with `ub_n` low.
- R6: With both `lb_n` and `ub_n` high, a beat drives nothing and stores nothing. The burst stays open and the address still advances.
- R7: A refresh of REF_LEN cycles (default 4) falls due once every REF_PERIOD clocks (default 64). Suppose an access starts on the edge where a refresh falls due. `wait_o` is then high for REF_LEN+1+LAT_CYC cycles. Suppose instead the access starts while a refresh still has k edges to run. `wait_o` is then high for k+LAT_CYC cycles.
- R8: After a beat at an address whose low log2(ROW_WORDS) bits are all ones, `wait_o` is high for ROW_STALL cycles (default 2). The next beat then uses the following address.
- R9: A refresh that falls due during a burst waits for the next row crossing, where the stall becomes REF_LEN+1+ROW_STALL cycles, or for the end of the burst. When it runs at the end of the burst, an access started on the next edge sees REF_LEN+LAT_CYC stall cycles. A refresh never runs while beats move.
- R10: If `ce_n` rises during the initial stall, the access is dropped. On the next edge `wait_o` falls and `corrupt` pulses high for one cycle.
- R11: If `ce_n` is seen high at an edge while beats are moving, the burst ends. On the next edge `wait_o` and `dq_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on rising edges |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Active-low chip enable; low opens and holds a burst |
| we_n | input | 1 | Active-low write select, sampled when the burst opens |
| addr | input | AW | Start word address, sampled when the burst opens |
| lb_n | input | 1 | Active-low enable for bits 7:0 |
| ub_n | input | 1 | Active-low enable for bits 15:8 |
| dq_in | input | 16 | Write data from the master |
| dq_out | output | 16 | Read data; zero on lanes not driven |
| dq_oe | output | 2 | Per-lane output enable (bit 0 low byte, bit 1 high byte) |
| wait_o | output | 1 | Registered stall indication, active high |
| corrupt | output | 1 | One-cycle pulse when an access is dropped during its initial stall |

## Verification
The interesting overlap is a refresh falling due on the very edge that opens an access, or a refresh falling due while beats are moving and then meeting a row crossing. The bench tracks a behavioural model of the refresh timer. It uses that timer to open one burst exactly on a due edge and another while a refresh is running. It then times a long burst so that a refresh falls due in mid-transfer before the row ends. The lengths of the observed `wait_o` runs are compared with the sums given in R7 and R9. A cycle-level model also compares every output on every clock.

// File: rtl/bpsram_pkg.sv
package bpsram_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,   // no burst open
    ST_RFW,    // access waits for a refresh to finish
    ST_LAT,    // initial latency
    ST_XFER,   // beats moving
    ST_RRF,    // row crossing, deferred refresh running
    ST_ROW     // row crossing stall
  } bst_t;
endpackage

// File: rtl/bpsram_refresh.sv
module bpsram_refresh #(
  parameter int PERIOD = 64,
  parameter int LEN    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_go,
  output logic ref_req,
  output logic ref_busy
);
  localparam int TW = $clog2(PERIOD);
  localparam int LW = $clog2(LEN + 1);

  logic [TW-1:0] tmr;
  logic [LW-1:0] left;
  logic          pend;
  logic          due;

  assign due      = (tmr == TW'(PERIOD - 1));
  assign ref_req  = pend | due;
  assign ref_busy = (left != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr  <= '0;
      left <= '0;
      pend <= 1'b0;
    end else begin
      tmr <= due ? '0 : tmr + 1'b1;
      if (ref_go) begin
        left <= LW'(LEN);
        pend <= 1'b0;
      end else begin
        if (due) pend <= 1'b1;
        if (left != '0) left <= left - 1'b1;
      end
    end
  end
endmodule

// File: rtl/bpsram_array.sv
module bpsram_array #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    wr_lane,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wdata,
  output logic [15:0]   rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [7:0] lane_mem [DEPTH];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) lane_mem[i] <= '0;
      end else if (wr_lane[g]) begin
        lane_mem[addr] <= wdata[8*g +: 8];
      end
    end

    assign rdata[8*g +: 8] = lane_mem[addr];
  end
endmodule

// File: rtl/bpsram_ctrl.sv
module bpsram_ctrl
  import bpsram_pkg::*;
#(
  parameter int AW        = 9,
  parameter int ROW_WORDS = 128,
  parameter int LAT_CYC   = 3,
  parameter int ROW_STALL = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr_in,
  input  logic          ref_req,
  input  logic          ref_busy,
  output logic          ref_go,
  output logic [AW-1:0] cur_addr,
  output logic          wr_burst,
  output logic          xfer,
  output logic          wait_q,
  output logic          corrupt
);
  localparam int RBW  = $clog2(ROW_WORDS);
  localparam int MAXC = (LAT_CYC > ROW_STALL) ? LAT_CYC : ROW_STALL;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LAT_LD = CW'(LAT_CYC - 1);
  localparam logic [CW-1:0] ROW_LD = CW'(ROW_STALL - 1);

  bst_t          st, nxt;
  logic [CW-1:0] cnt, cnt_n;
  logic [AW-1:0] addr_q, addr_n;
  logic          wr_q, wr_n, abort, go, row_end;

  assign row_end = &addr_q[RBW-1:0];

  always_comb begin
    nxt    = st;
    cnt_n  = cnt;
    addr_n = addr_q;
    wr_n   = wr_q;
    go     = 1'b0;
    abort  = 1'b0;
    unique case (st)
      ST_IDLE: begin
        go = ref_req & ~ref_busy;
        if (!ce_n) begin
          addr_n = addr_in;
          wr_n   = ~we_n;
          if (ref_busy | go) nxt = ST_RFW;
          else begin
            nxt   = ST_LAT;
            cnt_n = LAT_LD;
          end
        end
      end
      ST_RFW: begin
        if (ce_n) begin
          nxt   = ST_IDLE;
          abort = 1'b1;
        end else if (!ref_busy) begin
          nxt   = ST_LAT;
          cnt_n = LAT_LD;
        end
      end
      ST_LAT: begin
        if (ce_n) begin
          nxt   = ST_IDLE;
          abort = 1'b1;
        end else if (cnt == '0) nxt = ST_XFER;
        else cnt_n = cnt - 1'b1;
      end
      ST_XFER: begin
        if (ce_n) begin
          nxt = ST_IDLE;
          go  = ref_req & ~ref_busy;
        end else begin
          addr_n = addr_q + 1'b1;
          if (row_end) begin
            if (ref_req & ~ref_busy) begin
              go  = 1'b1;
              nxt = ST_RRF;
            end else begin
              nxt   = ST_ROW;
              cnt_n = ROW_LD;
            end
          end
        end
      end
      ST_RRF: begin
        if (ce_n) nxt = ST_IDLE;
        else if (!ref_busy) begin
          nxt   = ST_ROW;
          cnt_n = ROW_LD;
        end
      end
      ST_ROW: begin
        if (ce_n) nxt = ST_IDLE;
        else if (cnt == '0) nxt = ST_XFER;
        else cnt_n = cnt - 1'b1;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      wait_q  <= 1'b0;
      corrupt <= 1'b0;
    end else begin
      st      <= nxt;
      cnt     <= cnt_n;
      addr_q  <= addr_n;
      wr_q    <= wr_n;
      wait_q  <= !(nxt == ST_IDLE || nxt == ST_XFER);
      corrupt <= abort;
    end
  end

  assign ref_go   = go;
  assign cur_addr = addr_q;
  assign wr_burst = wr_q;
  assign xfer     = (st == ST_XFER);
endmodule

// File: rtl/bpsram_wait.sv
module bpsram_wait #(
  parameter int AW         = 9,
  parameter int ROW_WORDS  = 128,
  parameter int LAT_CYC    = 3,
  parameter int ROW_STALL  = 2,
  parameter int REF_PERIOD = 64,
  parameter int REF_LEN    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic          lb_n,
  input  logic          ub_n,
  input  logic [15:0]   dq_in,
  output logic [15:0]   dq_out,
  output logic [1:0]    dq_oe,
  output logic          wait_o,
  output logic          corrupt
);
  logic          ref_go, ref_req, ref_busy;
  logic [AW-1:0] cur_addr;
  logic          wr_burst, xfer, beat;
  logic [1:0]    lane_on, wr_lane;
  logic [15:0]   rdata;

  bpsram_refresh #(.PERIOD(REF_PERIOD), .LEN(REF_LEN)) u_ref (
    .clk(clk), .rst_n(rst_n), .ref_go(ref_go),
    .ref_req(ref_req), .ref_busy(ref_busy)
  );

  bpsram_ctrl #(
    .AW(AW), .ROW_WORDS(ROW_WORDS), .LAT_CYC(LAT_CYC), .ROW_STALL(ROW_STALL)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr_in(addr),
    .ref_req(ref_req), .ref_busy(ref_busy), .ref_go(ref_go),
    .cur_addr(cur_addr), .wr_burst(wr_burst), .xfer(xfer),
    .wait_q(wait_o), .corrupt(corrupt)
  );

  assign beat    = xfer & ~ce_n;
  assign lane_on = {2{beat}} & ~{ub_n, lb_n};
  assign wr_lane = lane_on & {2{wr_burst}};
  assign dq_oe   = lane_on & {2{~wr_burst}};

  bpsram_array #(.AW(AW)) u_arr (
    .clk(clk), .rst_n(rst_n), .wr_lane(wr_lane), .addr(cur_addr),
    .wdata(dq_in), .rdata(rdata)
  );

  assign dq_out = rdata & {{8{dq_oe[1]}}, {8{dq_oe[0]}}};
endmodule

// File: rtl/bpsram_chk.sv
module bpsram_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_n,
  input logic       lb_n,
  input logic       ub_n,
  input logic [1:0] dq_oe,
  input logic       wait_o,
  input logic       corrupt,
  input logic       ref_go,
  input logic       ref_busy,
  input logic       xfer
);
  p_stall_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wait_o |-> dq_oe == 2'b00);

  p_low_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe[0] |-> (!lb_n && !ce_n));

  p_high_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe[1] |-> (!ub_n && !ce_n));

  p_both_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_n && ub_n) |-> dq_oe == 2'b00);

  p_ref_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_go |=> ref_busy);

  p_ref_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_go |-> !ref_busy);

  p_no_ref_in_xfer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |-> !ref_busy);

  p_corrupt_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    corrupt |=> !corrupt);

  p_corrupt_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    corrupt |-> ($past(wait_o) && $past(ce_n) && !wait_o));
endmodule

bind bpsram_wait bpsram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .lb_n(lb_n), .ub_n(ub_n),
  .dq_oe(dq_oe), .wait_o(wait_o), .corrupt(corrupt),
  .ref_go(ref_go), .ref_busy(ref_busy), .xfer(xfer)
);

// File: tb/bpsram_wait_test.sv
module bpsram_wait_test;
  localparam int AW = 9, DEPTH = 512, LAT = 3, ROW = 128, ROWST = 2;
  localparam int RP = 64, RL = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, ce_n, we_n, lb_n, ub_n, wait_o, corrupt;
  logic [AW-1:0] addr_i;
  logic [15:0] dq_in, dq_out;
  logic [1:0] dq_oe;

  bpsram_wait #(.AW(AW), .ROW_WORDS(ROW), .LAT_CYC(LAT), .ROW_STALL(ROWST),
                .REF_PERIOD(RP), .REF_LEN(RL)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr_i),
    .lb_n(lb_n), .ub_n(ub_n), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe(dq_oe), .wait_o(wait_o), .corrupt(corrupt)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model: phases 0 idle,1 wait-refresh,2 latency,3 transfer,4 row+refresh,5 row
  int m_ph, m_cnt, m_tmr, m_pend, m_rb, m_addr;
  bit m_wr, m_wait, m_corr;
  logic [15:0] mem_m [DEPTH];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_tmr = 0; m_pend = 0; m_rb = 0; m_addr = 0;
      m_wr = 0; m_wait = 0; m_corr = 0;
      for (int i = 0; i < DEPTH; i++) mem_m[i] = 16'h0;
    end else begin
      bit due, req, busy, go, corr;
      int nph;
      due = (m_tmr == RP - 1);
      req = m_pend != 0 || due;
      busy = m_rb != 0;
      go = 0; corr = 0; nph = m_ph;
      case (m_ph)
        0: begin
          go = req && !busy;
          if (!ce_n) begin
            m_addr = int'(addr_i); m_wr = !we_n;
            if (busy || go) nph = 1; else begin nph = 2; m_cnt = LAT - 1; end
          end
        end
        1: if (ce_n) begin nph = 0; corr = 1; end
           else if (!busy) begin nph = 2; m_cnt = LAT - 1; end
        2: if (ce_n) begin nph = 0; corr = 1; end
           else if (m_cnt == 0) nph = 3; else m_cnt--;
        3: if (ce_n) begin nph = 0; go = req && !busy; end
           else begin
             if (m_wr) begin
               if (!lb_n) mem_m[m_addr][7:0] = dq_in[7:0];
               if (!ub_n) mem_m[m_addr][15:8] = dq_in[15:8];
             end
             if (m_addr % ROW == ROW - 1) begin
               if (req && !busy) begin go = 1; nph = 4; end
               else begin nph = 5; m_cnt = ROWST - 1; end
             end
             m_addr = (m_addr + 1) % DEPTH;
           end
        4: if (ce_n) nph = 0;
           else if (!busy) begin nph = 5; m_cnt = ROWST - 1; end
        default: if (ce_n) nph = 0;
           else if (m_cnt == 0) nph = 3; else m_cnt--;
      endcase
      if (go) begin m_rb = RL; m_pend = 0; end
      else begin if (due) m_pend = 1; if (m_rb > 0) m_rb--; end
      m_tmr = due ? 0 : m_tmr + 1;
      m_ph = nph;
      m_wait = !(nph == 0 || nph == 3);
      m_corr = corr;
    end
  end

  // per-cycle comparison, 1 ns before the next rising edge
  always @(negedge clk) begin
    #3;
    if (rst_n) begin
      bit bt;
      logic [1:0] oe_e;
      bt = (m_ph == 3) && !ce_n;
      oe_e = {bt && !m_wr && !ub_n, bt && !m_wr && !lb_n};
      chk(wait_o === m_wait, "R2", "wait_o per cycle", int'(wait_o), int'(m_wait));
      chk(corrupt === m_corr, "R10", "corrupt per cycle", int'(corrupt), int'(m_corr));
      chk(dq_oe === oe_e, "R5", "dq_oe per cycle", int'(dq_oe), int'(oe_e));
      if (oe_e[0])
        chk(dq_out[7:0] === mem_m[m_addr][7:0], "R3", "low byte", int'(dq_out[7:0]),
            int'(mem_m[m_addr][7:0]));
      if (oe_e[1])
        chk(dq_out[15:8] === mem_m[m_addr][15:8], "R3", "high byte", int'(dq_out[15:8]),
            int'(mem_m[m_addr][15:8]));
    end
  end

  int stalls[$];
  logic [15:0] rdq[$];
  bit oe_seen;

  function automatic int st_at(input int i);
    return (i < stalls.size()) ? stalls[i] : -1;
  endfunction

  task automatic burst(input int at_tmr, input int a, input bit wr, input int n,
                       input bit lbn, input bit ubn, input logic [15:0] base);
    int k = 0, run = 0;
    stalls.delete(); rdq.delete(); oe_seen = 0;
    @(negedge clk);
    if (at_tmr >= 0) while (m_tmr != at_tmr) @(negedge clk);
    ce_n = 0; we_n = !wr; addr_i = AW'(a); lb_n = lbn; ub_n = ubn; dq_in = base;
    while (k < n) begin
      @(negedge clk);
      if (dq_oe != 2'b00) oe_seen = 1;
      if (wait_o) run++;
      else begin
        if (run > 0) stalls.push_back(run);
        run = 0;
        dq_in = base + 16'(k);
        if (!wr) rdq.push_back(dq_out);
        k++;
      end
    end
    @(negedge clk);
    ce_n = 1; we_n = 1;
  endtask

  initial begin
    rst_n = 0; ce_n = 1; we_n = 1; lb_n = 0; ub_n = 0; addr_i = '0; dq_in = '0;
    repeat (3) @(negedge clk);
    chk(wait_o === 1'b0 && dq_oe === 2'b00 && corrupt === 1'b0, "R1", "reset outputs",
        int'({wait_o, dq_oe, corrupt}), 0);
    rst_n = 1;
    @(negedge clk);
    chk(wait_o === 1'b0 && corrupt === 1'b0, "R1", "idle after reset",
        int'({wait_o, corrupt}), 0);

    // R2 R4: plain write of six words
    burst(2, 120, 1, 6, 0, 0, 16'hA000);
    chk(st_at(0) == LAT, "R2", "write initial stall", st_at(0), LAT);
    // R3: read back
    burst(20, 120, 0, 6, 0, 0, 16'h0);
    chk(st_at(0) == LAT, "R2", "read initial stall", st_at(0), LAT);
    chk(rdq.size() == 6 && rdq[5] == 16'hA005, "R3", "linear read last word",
        (rdq.size() == 6) ? int'(rdq[5]) : -1, 16'hA005);
    @(negedge clk);
    chk(wait_o === 1'b0 && dq_oe === 2'b00, "R11", "burst closed",
        int'({wait_o, dq_oe}), 0);

    // R4: lane masking on writes
    burst(40, 121, 1, 2, 1, 0, 16'h5500);
    burst(52, 123, 1, 1, 0, 1, 16'h77CC);
    // R6: both lanes off, nothing stored
    burst(10, 124, 1, 1, 1, 1, 16'hFFFF);
    burst(20, 120, 0, 6, 0, 0, 16'h0);
    chk(rdq.size() == 6 && rdq[1] == 16'h5501, "R4", "upper-only write",
        (rdq.size() == 6) ? int'(rdq[1]) : -1, 16'h5501);
    chk(rdq.size() == 6 && rdq[2] == 16'h5502, "R4", "upper-only write 2",
        (rdq.size() == 6) ? int'(rdq[2]) : -1, 16'h5502);
    chk(rdq.size() == 6 && rdq[3] == 16'hA0CC, "R4", "lower-only write",
        (rdq.size() == 6) ? int'(rdq[3]) : -1, 16'hA0CC);
    chk(rdq.size() == 6 && rdq[4] == 16'hA004, "R6", "no store with lanes off",
        (rdq.size() == 6) ? int'(rdq[4]) : -1, 16'hA004);
    burst(40, 120, 0, 2, 1, 1, 16'h0);
    chk(oe_seen == 0 && rdq.size() == 2, "R6", "no drive with lanes off",
        int'(oe_seen), 0);

    // R8: row crossing
    burst(2, 126, 0, 4, 0, 0, 16'h0);
    chk(st_at(1) == ROWST, "R8", "row crossing stall", st_at(1), ROWST);
    chk(rdq.size() == 4, "R8", "beats after crossing", rdq.size(), 4);

    // R7: start on the edge a refresh falls due, then while one runs
    burst(RP - 1, 120, 0, 2, 0, 0, 16'h0);
    chk(st_at(0) == RL + 1 + LAT, "R7", "start on due edge", st_at(0), RL + 1 + LAT);
    burst(1, 120, 0, 2, 0, 0, 16'h0);
    chk(st_at(0) == (RL - 1) + LAT, "R7", "start during refresh", st_at(0),
        (RL - 1) + LAT);

    // R9: refresh deferred to the row crossing
    burst(40, 100, 0, 40, 0, 0, 16'h0);
    chk(st_at(0) == LAT, "R9", "initial stall of long burst", st_at(0), LAT);
    chk(st_at(1) == RL + 1 + ROWST, "R9", "crossing with deferred refresh", st_at(1),
        RL + 1 + ROWST);
    // R9: refresh deferred to the end of the burst
    burst(50, 0, 0, 20, 0, 0, 16'h0);
    chk(stalls.size() == 1, "R9", "no stall mid-row", stalls.size(), 1);
    burst(-1, 0, 0, 1, 0, 0, 16'h0);
    chk(st_at(0) == RL + LAT, "R9", "refresh run at burst end", st_at(0), RL + LAT);

    // R10: abort during the initial latency
    @(negedge clk);
    while (m_tmr != 10) @(negedge clk);
    ce_n = 0; we_n = 0; addr_i = AW'(5); dq_in = 16'h1234; lb_n = 0; ub_n = 0;
    @(negedge clk);
    chk(wait_o === 1'b1, "R10", "stall before abort", int'(wait_o), 1);
    ce_n = 1; we_n = 1;
    @(negedge clk);
    chk(corrupt === 1'b1 && wait_o === 1'b0, "R10", "abort flagged",
        int'({corrupt, wait_o}), 2);
    @(negedge clk);
    chk(corrupt === 1'b0, "R10", "flag lasts one cycle", int'(corrupt), 0);
    burst(20, 5, 0, 1, 0, 0, 16'h0);
    chk(rdq.size() == 1 && rdq[0] == 16'h0000, "R10", "aborted write not stored",
        (rdq.size() == 1) ? int'(rdq[0]) : -1, 0);

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule